// File: doc/BRIEF.md
# Receive FIFO Trigger, Timeout and DMA-Ready Control

This block is the status and interrupt logic that sits beside the 16-entry receive and transmit queues of one serial channel. It does not store characters. It watches the occupancy counts of both queues, a pulse marking the middle of each received stop bit, the host's read strobe on the receive holding register and a 16x bit-rate tick. From these it raises the receive-data interrupt, the receive timeout interrupt, and the active-low receive-ready and transmit-ready pins used by a DMA engine.

The host picks one of four receive trigger levels with a two-bit field. The host sets the character format: data length, parity on or off, and stop-bit length. The timeout window is derived from that format and lasts four character times. A mode bit changes the meaning of the two ready pins. In single-transfer mode they follow "any data" and "fully empty". In block mode they follow "trigger reached" and "any free slot".

Top module: `uart_rxq_status`

## Requirements
- R1: `trigSel` encodes the receive trigger level as 0 = 1 character, 1 = 4, 2 = 8 and 3 = 14 characters.
- R2: `rxDataIrq` is high in the cycle after `rxCount` is at or above the selected trigger level, and low otherwise.
- R3: `rxTimeoutIrq` sets on the 4×C-th `tick16` pulse counted while the receive queue is not empty, with no restart in between. C = 16×(1 + data bits + parity bit) + stop ticks. `wordLen` 0..3 selects 5..8 data bits. `parityOn` adds 1 bit. `stopSel` gives 16 stop ticks for 0, 24 for 1 and 32 for 2 or 3. The flag is visible one cycle after that pulse.
- R4: A `stopCentre` pulse or an `rhrRead` pulse restarts the timeout count from zero.
- R5: No timeout is raised while `rxCount` is 0, however many ticks arrive.
- R6: `rxIrq` is the shared receive interrupt. It is high whenever `rxDataIrq` or `rxTimeoutIrq` is high.
- R7: With `dmaMode` = 1, `rxRdyN` is low exactly when `rxCount` is at or above the trigger level, one cycle later.
- R8: With `dmaMode` = 1, `txRdyN` is low while `txCount` is below 16 and high when it equals 16, one cycle later.
- R9: With `dmaMode` = 0, `rxRdyN` is low whenever `rxCount` is nonzero, one cycle later.
- R10: With `dmaMode` = 0, `txRdyN` is low only when `txCount` is 0, one cycle later.
- R11: The timeout flag clears the cycle after an `rhrRead` pulse. It also clears the cycle after `rxCount` is 0.
- R12: While `rstN` is low, all interrupts are low and both ready pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxCount | input | 5 | Characters held in the receive queue (0..16) |
| txCount | input | 5 | Characters held in the transmit queue (0..16) |
| stopCentre | input | 1 | One-cycle pulse at the middle of each received stop bit |
| rhrRead | input | 1 | One-cycle pulse when the host reads the receive holding register |
| tick16 | input | 1 | One-cycle pulse per 16x bit-rate tick |
| trigSel | input | 2 | Receive trigger level select |
| wordLen | input | 2 | Data bits minus 5 |
| parityOn | input | 1 | Parity bit present |
| stopSel | input | 2 | Stop length: 0 = 1 bit, 1 = 1.5 bits, 2 or 3 = 2 bits |
| dmaMode | input | 1 | 0 = single-transfer mode, 1 = block mode |
| rxDataIrq | output | 1 | Receive trigger level reached |
| rxTimeoutIrq | output | 1 | Receive timeout flag |
| rxIrq | output | 1 | Shared receive interrupt |
| rxRdyN | output | 1 | Active-low receive ready |
| txRdyN | output | 1 | Active-low transmit ready |

## Verification
The timeout counter is the only deep state in this block. A counter that is off by one, or one that misses a restart, shows on `rxTimeoutIrq` one tick early or one tick late. It can also show the flag after a restart that should have prevented it. To catch this, the bench checks the flag just before and just after the exact tick count for two character formats. It also checks across a stop-bit restart. A wrong trigger decode or a swapped ready-pin mode appears on `rxDataIrq`, `rxRdyN` or `txRdyN` one cycle after the count crosses the boundary. The bench therefore steps the counts to one below, at, and above each level.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Strobes sent from the control half to the datapath half.
  typedef struct packed {
    logic cntClear;   // restart the timeout count
    logic cntRun;     // one 16x tick to count
  } rxqStrobe_t;

  // Conditions the datapath reports back to the control half.
  typedef struct packed {
    logic expire;     // timeout count reached its limit this tick
    logic atTrig;     // receive count at or above the trigger level
    logic rxAny;      // receive queue holds at least one character
    logic txFull;     // transmit queue has no free slot
    logic txEmpty;    // transmit queue holds nothing
  } rxqStatus_t;

  // Map the trigger select field to a character count.
  function automatic int trigLevel(input logic [1:0] sel, input int depth);
    case (sel)
      2'd0:    trigLevel = 1;
      2'd1:    trigLevel = 4;
      2'd2:    trigLevel = 8;
      default: trigLevel = depth - 2;
    endcase
  endfunction

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath #(
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  rxq_pkg::rxqStrobe_t            strobe,
  input  logic [$clog2(DEPTH+1)-1:0]     rxCount,
  input  logic [$clog2(DEPTH+1)-1:0]     txCount,
  input  logic [1:0]                     trigSel,
  input  logic [1:0]                     wordLen,
  input  logic                           parityOn,
  input  logic [1:0]                     stopSel,
  output rxq_pkg::rxqStatus_t            status
);
  localparam int CW       = $clog2(DEPTH + 1);
  localparam int MAX_BITS = 1 + 8 + 1;
  localparam int MAX_LIM  = TIMEOUT_CHARS * (MAX_BITS * TICKS_PER_BIT + 2 * TICKS_PER_BIT);
  localparam int LW       = $clog2(MAX_LIM + 1);
  localparam int HALF_BIT = TICKS_PER_BIT / 2;

  logic [LW-1:0] limit;
  logic [LW-1:0] cnt;
  logic [LW:0]   cntNext;
  int            stopTicks;
  int            bodyBits;
  int            limitInt;

  // Character-time window derived from the programmed format.
  always_comb begin
    bodyBits = 1 + 5 + int'(wordLen) + int'(parityOn);
    case (stopSel)
      2'd0:    stopTicks = TICKS_PER_BIT;
      2'd1:    stopTicks = TICKS_PER_BIT + HALF_BIT;
      default: stopTicks = 2 * TICKS_PER_BIT;
    endcase
    limitInt = TIMEOUT_CHARS * (bodyBits * TICKS_PER_BIT + stopTicks);
    limit    = limitInt[LW-1:0];
  end

  assign cntNext = {1'b0, cnt} + {{LW{1'b0}}, 1'b1};

  // Timeout counter: restarts on clear, saturates at the limit.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.cntClear) begin
      cnt <= '0;
    end else if (strobe.cntRun && (cnt < limit)) begin
      cnt <= cntNext[LW-1:0];
    end
  end

  always_comb begin
    status.expire  = strobe.cntRun && !strobe.cntClear && (cntNext == {1'b0, limit});
    status.atTrig  = int'(rxCount) >= rxq_pkg::trigLevel(trigSel, DEPTH);
    status.rxAny   = rxCount != '0;
    status.txFull  = txCount == CW'(DEPTH);
    status.txEmpty = txCount == '0;
  end

endmodule

// File: rtl/rxq_control.sv
module rxq_control (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 stopCentre,
  input  logic                 rhrRead,
  input  logic                 tick16,
  input  logic                 dmaMode,
  input  rxq_pkg::rxqStatus_t  status,
  output rxq_pkg::rxqStrobe_t  strobe,
  output logic                 rxDataIrq,
  output logic                 rxTimeoutIrq,
  output logic                 rxIrq,
  output logic                 rxRdyN,
  output logic                 txRdyN
);
  logic toNext;
  logic dataNext;
  logic flagClear;

  // A read or an empty queue ends a pending timeout; stop centres only restart.
  assign flagClear       = rhrRead || !status.rxAny;
  assign strobe.cntClear = stopCentre || flagClear;
  assign strobe.cntRun   = tick16;

  always_comb begin
    dataNext = status.atTrig;
    if (flagClear)          toNext = 1'b0;
    else if (status.expire) toNext = 1'b1;
    else                    toNext = rxTimeoutIrq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxDataIrq    <= 1'b0;
      rxTimeoutIrq <= 1'b0;
      rxIrq        <= 1'b0;
      rxRdyN       <= 1'b1;
      txRdyN       <= 1'b1;
    end else begin
      rxDataIrq    <= dataNext;
      rxTimeoutIrq <= toNext;
      rxIrq        <= dataNext || toNext;
      if (dmaMode) begin
        rxRdyN <= !status.atTrig;
        txRdyN <= status.txFull;
      end else begin
        rxRdyN <= !status.rxAny;
        txRdyN <= !status.txEmpty;
      end
    end
  end

endmodule

// File: rtl/uart_rxq_status.sv
module uart_rxq_status #(
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16,
  parameter int TIMEOUT_CHARS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [$clog2(DEPTH+1)-1:0] rxCount,
  input  logic [$clog2(DEPTH+1)-1:0] txCount,
  input  logic                       stopCentre,
  input  logic                       rhrRead,
  input  logic                       tick16,
  input  logic [1:0]                 trigSel,
  input  logic [1:0]                 wordLen,
  input  logic                       parityOn,
  input  logic [1:0]                 stopSel,
  input  logic                       dmaMode,
  output logic                       rxDataIrq,
  output logic                       rxTimeoutIrq,
  output logic                       rxIrq,
  output logic                       rxRdyN,
  output logic                       txRdyN
);
  rxq_pkg::rxqStrobe_t strobe;
  rxq_pkg::rxqStatus_t status;

  rxq_datapath #(
    .DEPTH(DEPTH), .TICKS_PER_BIT(TICKS_PER_BIT), .TIMEOUT_CHARS(TIMEOUT_CHARS)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rxCount(rxCount), .txCount(txCount), .trigSel(trigSel),
    .wordLen(wordLen), .parityOn(parityOn), .stopSel(stopSel),
    .status(status)
  );

  rxq_control uControl (
    .clk(clk), .rstN(rstN), .stopCentre(stopCentre), .rhrRead(rhrRead),
    .tick16(tick16), .dmaMode(dmaMode), .status(status), .strobe(strobe),
    .rxDataIrq(rxDataIrq), .rxTimeoutIrq(rxTimeoutIrq), .rxIrq(rxIrq),
    .rxRdyN(rxRdyN), .txRdyN(txRdyN)
  );

endmodule

// File: rtl/rxq_status_chk.sv
module rxq_status_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [$clog2(DEPTH+1)-1:0] rxCount,
  input logic [$clog2(DEPTH+1)-1:0] txCount,
  input logic                       rhrRead,
  input logic                       tick16,
  input logic                       dmaMode,
  input logic                       rxDataIrq,
  input logic                       rxTimeoutIrq,
  input logic                       rxIrq,
  input logic                       rxRdyN,
  input logic                       txRdyN
);
  logic armed;
  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  // R5 / R11: an empty queue leaves no timeout flag behind
  a_r5_no_timeout_empty: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (rxCount == '0) |=> !rxTimeoutIrq);

  // R11: a read of the holding register drops the flag
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rstN || !armed)
    rhrRead |=> !rxTimeoutIrq);

  // R3: the flag only rises right after a counted tick
  a_r3_rise_on_tick: assert property (@(posedge clk) disable iff (!rstN || !armed)
    $rose(rxTimeoutIrq) |-> $past(tick16));

  // R6: the shared interrupt covers both sources
  a_r6_shared_irq: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (rxDataIrq || rxTimeoutIrq) |-> rxIrq);

  // R8: block mode, full transmit queue, ready pin released
  a_r8_tx_full: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (dmaMode && txCount == ($clog2(DEPTH+1))'(DEPTH)) |=> txRdyN);

  // R7 / R9: empty receive queue never shows ready
  a_r9_rx_empty: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (rxCount == '0) |=> rxRdyN);

  // R12: reset values
  a_r12_reset: assert property (@(posedge clk)
    !rstN |=> (!rxIrq && rxRdyN && txRdyN));

endmodule

bind uart_rxq_status rxq_status_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .rxCount(rxCount), .txCount(txCount),
  .rhrRead(rhrRead), .tick16(tick16), .dmaMode(dmaMode),
  .rxDataIrq(rxDataIrq), .rxTimeoutIrq(rxTimeoutIrq), .rxIrq(rxIrq),
  .rxRdyN(rxRdyN), .txRdyN(txRdyN)
);

// File: tb/uart_rxq_status_test.sv
module uart_rxq_status_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] rxCount = '0;
  logic [4:0] txCount = '0;
  logic       stopCentre = 1'b0;
  logic       rhrRead = 1'b0;
  logic       tick16 = 1'b0;
  logic [1:0] trigSel = '0;
  logic [1:0] wordLen = '0;
  logic       parityOn = 1'b0;
  logic [1:0] stopSel = '0;
  logic       dmaMode = 1'b0;
  logic       rxDataIrq, rxTimeoutIrq, rxIrq, rxRdyN, txRdyN;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct {
    string tag;
    int    sel;   // 0 dataIrq, 1 timeout, 2 rxIrq, 3 rxRdyN, 4 txRdyN
    bit    exp;
  } expItem_t;
  expItem_t sbq[$];

  always #5 clk = ~clk;

  uart_rxq_status uut (
    .clk(clk), .rstN(rstN), .rxCount(rxCount), .txCount(txCount),
    .stopCentre(stopCentre), .rhrRead(rhrRead), .tick16(tick16),
    .trigSel(trigSel), .wordLen(wordLen), .parityOn(parityOn),
    .stopSel(stopSel), .dmaMode(dmaMode), .rxDataIrq(rxDataIrq),
    .rxTimeoutIrq(rxTimeoutIrq), .rxIrq(rxIrq), .rxRdyN(rxRdyN), .txRdyN(txRdyN)
  );

  function automatic bit pick(int sel);
    case (sel)
      0: pick = rxDataIrq;
      1: pick = rxTimeoutIrq;
      2: pick = rxIrq;
      3: pick = rxRdyN;
      default: pick = txRdyN;
    endcase
  endfunction

  // Monitor: compares queued expectations away from the active edge.
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      expItem_t it;
      bit act;
      it  = sbq.pop_front();
      act = pick(it.sel);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %0b expected %0b", it.tag, act, it.exp);
      end
    end
  end

  task automatic expect_out(string tag, int sel, bit exp);
    expItem_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    sbq.push_back(it);
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick16 = 1'b1; cyc(); tick16 = 1'b0; cyc();
    end
  endtask

  function automatic int trigOf(int sel);
    int lv[4] = '{1, 4, 8, 14};
    return lv[sel];
  endfunction

  function automatic int windowOf(int wl, int par, int st);
    int stopT;
    stopT = (st == 0) ? 16 : (st == 1) ? 24 : 32;
    return 4 * (16 * (1 + 5 + wl + par) + stopT);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual expired expected finished");
      summary();
    end
  end

  initial begin
    int lim;
    // R12 reset state
    cyc(); cyc();
    expect_out("R12 dataIrq", 0, 0); expect_out("R12 rxIrq", 2, 0);
    expect_out("R12 rxRdyN", 3, 1); expect_out("R12 txRdyN", 4, 1);
    cyc();
    rstN = 1'b1;
    cyc();

    // R1 / R2 / R6 trigger levels
    for (int s = 0; s < 4; s++) begin
      trigSel = 2'(s);
      rxCount = 5'(trigOf(s) - 1); cyc();
      expect_out($sformatf("R1 R2 sel%0d below", s), 0, 0);
      cyc();
      rxCount = 5'(trigOf(s)); cyc();
      expect_out($sformatf("R1 R2 sel%0d at", s), 0, 1);
      expect_out($sformatf("R6 sel%0d rxIrq", s), 2, 1);
      cyc();
      rxCount = 5'(trigOf(s) + 2); cyc();
      expect_out($sformatf("R2 sel%0d above", s), 0, 1);
      cyc();
    end

    // R7 block-mode receive ready, trigger 8
    dmaMode = 1'b1; trigSel = 2'd2;
    rxCount = 5'd7; cyc(); expect_out("R7 below trigger", 3, 1); cyc();
    rxCount = 5'd8; cyc(); expect_out("R7 at trigger", 3, 0); cyc();
    // R8 block-mode transmit ready
    txCount = 5'd15; cyc(); expect_out("R8 one free", 4, 0); cyc();
    txCount = 5'd16; cyc(); expect_out("R8 full", 4, 1); cyc();
    // R9 / R10 single-transfer mode
    dmaMode = 1'b0;
    rxCount = 5'd1; txCount = 5'd0; cyc();
    expect_out("R9 one char", 3, 0); expect_out("R10 tx empty", 4, 0); cyc();
    rxCount = 5'd0; txCount = 5'd1; cyc();
    expect_out("R9 empty", 3, 1); expect_out("R10 tx one", 4, 1); cyc();

    // R3 timeout, 8 data bits, no parity, 1 stop
    trigSel = 2'd3; rxCount = 5'd3;
    wordLen = 2'd3; parityOn = 1'b0; stopSel = 2'd0;
    rhrRead = 1'b1; cyc(); rhrRead = 1'b0; cyc();
    lim = windowOf(3, 0, 0);
    ticks(lim - 1);
    expect_out("R3 one tick short", 1, 0); cyc();
    ticks(1);
    expect_out("R3 expired", 1, 1); expect_out("R6 timeout rxIrq", 2, 1); cyc();
    // R11 read clears
    rhrRead = 1'b1; cyc(); rhrRead = 1'b0;
    expect_out("R11 read clears", 1, 0); cyc();

    // R4 stop-centre restart
    ticks(lim - 10);
    stopCentre = 1'b1; cyc(); stopCentre = 1'b0; cyc();
    ticks(lim - 1);
    expect_out("R4 restarted short", 1, 0); cyc();
    ticks(1);
    expect_out("R4 expired after restart", 1, 1); cyc();
    // R11 empty clears
    rxCount = 5'd0; cyc();
    expect_out("R11 empty clears", 1, 0); cyc();

    // R5 empty queue never times out
    ticks(lim + 5);
    expect_out("R5 empty no timeout", 1, 0); cyc();

    // R3 second format: 5 bits, parity, 1.5 stop
    rxCount = 5'd2; wordLen = 2'd0; parityOn = 1'b1; stopSel = 2'd1;
    rhrRead = 1'b1; cyc(); rhrRead = 1'b0; cyc();
    lim = windowOf(0, 1, 1);
    ticks(lim - 1);
    expect_out("R3 fmt2 short", 1, 0); cyc();
    ticks(1);
    expect_out("R3 fmt2 expired", 1, 1); cyc();

    cyc(); cyc();
    summary();
  end

endmodule